// File: doc/BRIEF.md
# Three-Decade BCD Event Counter with Holding Latches

This block counts events on a single-bit input. The input may change without regard to the system clock. It keeps the total as three binary-coded decimal digits: units, tens and hundreds. The input first passes through a synchronizer. Each falling transition then adds one to the total. The digits are carried into one another synchronously on the system clock.

Every decade feeds a four-bit holding stage that is governed by a latch-enable input. A downstream display scanner can therefore show either the live count or a frozen snapshot. A disable input stops counting and keeps the total. An active-high synchronous master reset clears the decades but leaves a held snapshot untouched. An overflow output pulses once for each thousand counted events, so that several blocks can be chained.

Top module: `bcd3_event_counter`

## Requirements
- R1: A falling transition of `cnt_i` adds exactly one to the count. A rising transition and a steady level add nothing.
- R2: Each decade steps 0 to 9, wraps to 0 and carries one into the next decade. Digit positions in `bcd_o`: units [3:0], tens [7:4], hundreds [11:8]. Digits are active-high BCD.
- R3: While `dis_i` is high, falling transitions are ignored and the count is held unchanged.
- R4: A clock edge that samples `rst_i` high sets all decades to zero. Reset takes priority over counting.
- R5: While `le_i` is low, `bcd_o` shows the live count.
- R6: While `le_i` is high, `bcd_o` keeps the count present just before `le_i` rose. It does not change with counting or reset.
- R7: `ovf_o` is high for exactly one clock, in the cycle when the count has just wrapped from 999 to 000. This gives one pulse per 1000 counted transitions.
- R8: With the default of two synchronizer stages, the count changes at the third rising clock edge after `cnt_i` falls, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, rising edge |
| rst_i | input | 1 | Synchronous master reset, active high |
| cnt_i | input | 1 | Event input, may be asynchronous |
| dis_i | input | 1 | Count disable, active high |
| le_i | input | 1 | Latch enable: low follows, high holds |
| bcd_o | output | 12 | Digits, hundreds:tens:units, 4 bits each |
| ovf_o | output | 1 | One-clock pulse on wrap from 999 |

## Verification
The bench drives whole counts through the carry boundaries at 9, 99 and 999. A design with a broken carry chain would show digits above 9, or would skip or double a carry into the tens or hundreds. It counts overflow pulses over a full thousand events. An overflow that is too wide, missing or repeated would change that tally. It also checks that a design counting on the rising transition is caught, because the count must stay unchanged while the input sits high. The count must change on exactly the third clock after the fall. Holding the latch across a master reset exposes a holding stage that is cleared by reset or that leaks the live count.

// File: rtl/bcdc_pkg.sv
package bcdc_pkg;
   localparam int unsigned BCD_W   = 4;
   localparam logic [BCD_W-1:0] BCD_MAX = 4'd9;
   typedef logic [BCD_W-1:0] bcd_t;
endpackage

// File: rtl/bcdc_fall_detect.sv
module bcdc_fall_detect #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic din_i,
   output logic fall_o
);
   logic [STAGES-1:0] sync_q;
   logic              last_q;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk_i) begin
            if (rst_i) sync_q <= '0;
            else       sync_q <= din_i;
         end
      end else begin : g_chain
         always_ff @(posedge clk_i) begin
            if (rst_i) sync_q <= '0;
            else       sync_q <= {sync_q[STAGES-2:0], din_i};
         end
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (rst_i) last_q <= 1'b0;
      else       last_q <= sync_q[STAGES-1];
   end

   assign fall_o = last_q & ~sync_q[STAGES-1];

   // R1: a detected fall is a single-cycle strobe
   p_fall_one_cycle_r1: assert property (@(posedge clk_i) disable iff (rst_i)
      fall_o |=> !fall_o);
endmodule

// File: rtl/bcdc_decade.sv
module bcdc_decade
   import bcdc_pkg::*;
(
   input  logic clk_i,
   input  logic rst_i,
   input  logic step_i,
   output bcd_t digit_o,
   output logic last_o
);
   bcd_t digit_q;

   always_ff @(posedge clk_i) begin
      if (rst_i)
         digit_q <= '0;
      else if (step_i)
         digit_q <= (digit_q == BCD_MAX) ? '0 : digit_q + 1'b1;
   end

   assign digit_o = digit_q;
   assign last_o  = (digit_q == BCD_MAX);

   p_digit_range_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      digit_q <= BCD_MAX);
   p_wrap_to_zero_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      (step_i && last_o) |=> (digit_q == '0));
   p_idle_hold_r3: assert property (@(posedge clk_i) disable iff (rst_i)
      !step_i |=> $stable(digit_q));
endmodule

// File: rtl/bcdc_hold_latch.sv
module bcdc_hold_latch #(
   parameter int unsigned W = 4
) (
   input  logic         clk_i,
   input  logic         le_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] held_q;

   always_ff @(posedge clk_i) begin
      if (!le_i) held_q <= d_i;
   end

   assign q_o = le_i ? held_q : d_i;

   // R6: a held snapshot does not move while enable stays high
   p_latch_hold_r6: assert property (@(posedge clk_i)
      le_i |=> (!le_i || $stable(q_o)));
endmodule

// File: rtl/bcd3_event_counter.sv
module bcd3_event_counter
   import bcdc_pkg::*;
#(
   parameter int unsigned NUM_DECADES = 3,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                         clk_i,
   input  logic                         rst_i,
   input  logic                         cnt_i,
   input  logic                         dis_i,
   input  logic                         le_i,
   output logic [NUM_DECADES*BCD_W-1:0] bcd_o,
   output logic                         ovf_o
);
   localparam int unsigned TOTAL_W = NUM_DECADES * BCD_W;

   initial begin
      assert (NUM_DECADES >= 1) else $fatal(1, "NUM_DECADES must be at least 1");
      assert (SYNC_STAGES >= 1) else $fatal(1, "SYNC_STAGES must be at least 1");
   end

   logic                   fall_w;
   logic [NUM_DECADES:0]   step_w;
   logic [NUM_DECADES-1:0] last_w;
   logic [TOTAL_W-1:0]     count_w;
   logic                   ovf_q;

   bcdc_fall_detect #(.STAGES(SYNC_STAGES)) u_fall (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .din_i  (cnt_i),
      .fall_o (fall_w)
   );

   assign step_w[0] = fall_w & ~dis_i;

   generate
      for (genvar i = 0; i < NUM_DECADES; i++) begin : g_dec
         bcd_t digit_w;

         bcdc_decade u_decade (
            .clk_i   (clk_i),
            .rst_i   (rst_i),
            .step_i  (step_w[i]),
            .digit_o (digit_w),
            .last_o  (last_w[i])
         );

         assign step_w[i+1] = step_w[i] & last_w[i];
         assign count_w[i*BCD_W +: BCD_W] = digit_w;

         bcdc_hold_latch #(.W(BCD_W)) u_hold (
            .clk_i (clk_i),
            .le_i  (le_i),
            .d_i   (digit_w),
            .q_o   (bcd_o[i*BCD_W +: BCD_W])
         );
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (rst_i) ovf_q <= 1'b0;
      else       ovf_q <= step_w[NUM_DECADES];
   end

   assign ovf_o = ovf_q;

   p_reset_clears_r4: assert property (@(posedge clk_i)
      rst_i |=> (count_w == '0));
   p_disable_hold_r3: assert property (@(posedge clk_i) disable iff (rst_i)
      dis_i |=> $stable(count_w));
   p_ovf_single_r7: assert property (@(posedge clk_i) disable iff (rst_i)
      ovf_o |=> !ovf_o);
   p_ovf_at_zero_r7: assert property (@(posedge clk_i) disable iff (rst_i)
      ovf_o |-> (count_w == '0));
endmodule

// File: tb/bcd3_event_counter_tb.sv
module bcd3_event_counter_tb;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cnt = 1'b0;
   logic        dis = 1'b0;
   logic        le  = 1'b0;
   logic [11:0] bcd;
   logic        ovf;

   int checks = 0;
   int fails  = 0;
   int ovf_seen = 0;
   int cycles = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   bcd3_event_counter u_dut (
      .clk_i (clk), .rst_i (rst), .cnt_i (cnt), .dis_i (dis),
      .le_i  (le),  .bcd_o (bcd), .ovf_o (ovf)
   );

   // row: [31:20] pulses, [16] disable, [11:0] expected BCD after the row
   localparam logic [31:0] VEC [7] = '{
      {12'd5,   3'b0, 1'b0, 4'b0, 12'h005},
      {12'd7,   3'b0, 1'b0, 4'b0, 12'h012},
      {12'd4,   3'b0, 1'b1, 4'b0, 12'h012},
      {12'd88,  3'b0, 1'b0, 4'b0, 12'h100},
      {12'd899, 3'b0, 1'b0, 4'b0, 12'h999},
      {12'd1,   3'b0, 1'b0, 4'b0, 12'h000},
      {12'd3,   3'b0, 1'b0, 4'b0, 12'h003}
   };

   always @(negedge clk) if (ovf) ovf_seen++;

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual %0d cycles, expected completion", cycles);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic pulses(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk) cnt = 1'b1;
         repeat (3) @(negedge clk);
         cnt = 1'b0;
         repeat (4) @(negedge clk);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check("R4 reset state", bcd, 12'h000);
      check("R7 no overflow after reset", {11'b0, ovf}, 12'h000);

      // vector table: R1 R2 R3 R5 R7
      for (int i = 0; i < 7; i++) begin
         dis = VEC[i][16];
         pulses(int'(VEC[i][31:20]));
         dis = 1'b0;
         check($sformatf("R2 row %0d count", i), bcd, VEC[i][11:0]);
         check($sformatf("R7 row %0d overflow tally", i), ovf_seen[11:0],
               (i >= 5) ? 12'h001 : 12'h000);
      end

      // R1 and R8: rising edge adds nothing; fall lands on third edge
      @(negedge clk) cnt = 1'b1;
      repeat (5) @(negedge clk);
      check("R1 rising edge ignored", bcd, 12'h003);
      cnt = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check("R8 no change after two edges", bcd, 12'h003);
      @(negedge clk);
      check("R8 change on third edge", bcd, 12'h004);
      repeat (3) @(negedge clk);

      // R6: hold through counting and reset
      le = 1'b1;
      pulses(2);
      check("R6 held during counting", bcd, 12'h004);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check("R6 held through reset", bcd, 12'h004);
      le = 1'b0;
      #1;
      check("R5 follows live count after release", bcd, 12'h000);

      // R4: reset wins over a simultaneous fall
      pulses(2);
      check("R5 live count", bcd, 12'h002);
      rst = 1'b1;
      pulses(1);
      rst = 1'b0;
      @(negedge clk);
      check("R4 reset priority over counting", bcd, 12'h000);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule